// File: doc/BRIEF.md
# Flag-Based Branch Resolution Unit

This block decides where a 32-bit RISC core goes next. Each decoded instruction arrives with an operation code, two register operand values, a sign-extended immediate and the program counter of that instruction. A compare instruction records two status flags: equal (Z) and unsigned-below (N). Six conditional branches test those flags. A branch never compares registers itself. Register-indirect jump and jump-and-link take their target from the first register operand, and the linking form also asks for a write of the return address into register 31. A system-call operation raises a trap request.

Instructions enter over a valid/ready handshake. Results leave over a second valid/ready handshake through a single output register. An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented from the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output field holds steady and no new instruction is accepted.

Top module: `cbu_branch_unit`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and both flags are 0. So a BNE or BGE issued before any compare is taken.
- R2: Operation code 1 (compare) sets Z when operand a equals operand b. It sets N when operand a is below operand b, compared as unsigned 32-bit values. The flags change only when a compare is accepted.
- R3: Operation code 2 (branch-if-equal) is taken when Z is 1. Code 3 (branch-if-not-equal) is taken when Z is 0.
- R4: Operation code 4 (branch-if-less) is taken when N is 1. Code 5 (branch-if-greater-or-equal) is taken when N is 0.
- R5: Operation code 6 (branch-if-less-or-equal) is taken when Z or N is 1. Code 7 (branch-if-greater) is taken when Z and N are both 0.
- R6: A taken branch produces a next PC equal to the instruction's PC plus four times the signed immediate, modulo 2^32.
- R7: A branch that is not taken produces a next PC equal to PC + 4. So do operation codes 0, 1 and 11 to 15.
- R8: Operation code 8 (jump) produces a next PC equal to operand a and no link write.
- R9: Operation code 9 (jump-and-link) produces a next PC equal to operand a. It sets `out_link_we` with `out_link_data` equal to PC + 4, and `out_link_reg` always reads 31.
- R10: Operation code 10 (system call) sets `out_trap` and produces a next PC equal to PC + 4.
- R11: `in_ready` equals `!out_valid || out_ready`. A result is valid in the cycle after its acceptance. While it is stalled, the result holds unchanged.
- R12: Each operation performs only its own action. `out_link_we` is set only for code 9, and `out_trap` only for code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_op | input | 4 | Operation code |
| in_rega | input | 32 | Register operand a |
| in_regb | input | 32 | Register operand b |
| in_imm | input | 32 | Sign-extended immediate |
| in_pc | input | 32 | PC of the instruction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | 32 | Next program counter |
| out_link_we | output | 1 | Write return address |
| out_link_reg | output | 5 | Link register index (31) |
| out_link_data | output | 32 | Return address |
| out_trap | output | 1 | System-call trap request |

## Verification
Every result is due exactly one rising edge after its acceptance. A compare's flags are visible to any instruction accepted on a later edge, including the very next cycle. The bench drives inputs and samples outputs at the falling edge. It logs each acceptance into a queue of expected results computed from its own flag model. On every cycle it requires `out_valid` to match whether the queue is non-empty, and it compares the head entry while it is presented. Randomly withheld `out_ready` exercises stalls, and `in_ready` is checked against the output-handshake rule right after each drive.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int XLEN = 32;
  localparam int REGW = 5;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_CMP  = 4'd1,
    OP_BEQ  = 4'd2,
    OP_BNE  = 4'd3,
    OP_BLT  = 4'd4,
    OP_BGE  = 4'd5,
    OP_BLE  = 4'd6,
    OP_BGT  = 4'd7,
    OP_JMP  = 4'd8,
    OP_JAL  = 4'd9,
    OP_SYS  = 4'd10
  } cbu_op_e;

  typedef struct packed {
    logic [XLEN-1:0] next_pc;
    logic            link_we;
    logic [XLEN-1:0] link_data;
    logic            trap;
  } cbu_res_t;
endpackage

// File: rtl/cbu_flags.sv
module cbu_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         flag_n,
  output logic         flag_z
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (upd) begin
      flag_z <= (opa == opb);
      flag_n <= (opa < opb);
    end
  end
endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
  import cbu_pkg::*;
(
  input  cbu_op_e op,
  input  logic    flag_n,
  input  logic    flag_z,
  output logic    is_branch,
  output logic    take
);
  always_comb begin
    is_branch = 1'b1;
    take      = 1'b0;
    unique case (op)
      OP_BEQ:  take = flag_z;
      OP_BNE:  take = !flag_z;
      OP_BLT:  take = flag_n;
      OP_BGE:  take = !flag_n;
      OP_BLE:  take = flag_z || flag_n;
      OP_BGT:  take = !flag_z && !flag_n;
      default: is_branch = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbu_target.sv
module cbu_target
  import cbu_pkg::*;
#(
  parameter int W = 32
) (
  input  cbu_op_e      op,
  input  logic         is_branch,
  input  logic         take,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] pc,
  output logic [W-1:0] next_pc,
  output logic         link_we,
  output logic [W-1:0] link_data,
  output logic         trap
);
  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0] seq_pc;
  logic [W-1:0] br_pc;

  assign seq_pc    = pc + STEP;
  assign br_pc     = pc + {imm[W-3:0], 2'b00};
  assign link_data = seq_pc;

  always_comb begin
    next_pc = seq_pc;
    link_we = 1'b0;
    trap    = 1'b0;
    if (is_branch) begin
      if (take) next_pc = br_pc;
    end else begin
      case (op)
        OP_JMP: next_pc = opa;
        OP_JAL: begin
          next_pc = opa;
          link_we = 1'b1;
        end
        OP_SYS:  trap = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbu_branch_unit.sv
module cbu_branch_unit
  import cbu_pkg::*;
#(
  parameter int W        = XLEN,
  parameter int RW       = REGW,
  parameter int LINK_REG = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [W-1:0]  in_rega,
  input  logic [W-1:0]  in_regb,
  input  logic [W-1:0]  in_imm,
  input  logic [W-1:0]  in_pc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_next_pc,
  output logic          out_link_we,
  output logic [RW-1:0] out_link_reg,
  output logic [W-1:0]  out_link_data,
  output logic          out_trap
);
  cbu_op_e      op;
  logic         accept;
  logic         flag_n, flag_z;
  logic         is_branch, take;
  logic [W-1:0] nx_pc, nx_link;
  logic         nx_we, nx_trap;

  assign op       = cbu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cbu_flags #(.W(W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (accept && (op == OP_CMP)),
    .opa    (in_rega),
    .opb    (in_regb),
    .flag_n (flag_n),
    .flag_z (flag_z)
  );

  cbu_cond u_cond (
    .op        (op),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .is_branch (is_branch),
    .take      (take)
  );

  cbu_target #(.W(W)) u_target (
    .op        (op),
    .is_branch (is_branch),
    .take      (take),
    .opa       (in_rega),
    .imm       (in_imm),
    .pc        (in_pc),
    .next_pc   (nx_pc),
    .link_we   (nx_we),
    .link_data (nx_link),
    .trap      (nx_trap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_next_pc   <= '0;
      out_link_we   <= 1'b0;
      out_link_data <= '0;
      out_trap      <= 1'b0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_next_pc   <= nx_pc;
      out_link_we   <= nx_we;
      out_link_data <= nx_link;
      out_trap      <= nx_trap;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_link_reg = RW'(LINK_REG);
endmodule

// File: rtl/cbu_chk.sv
module cbu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic [W-1:0] in_rega,
  input logic [W-1:0] in_regb,
  input logic [W-1:0] in_pc,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_next_pc,
  input logic         out_link_we,
  input logic [W-1:0] out_link_data,
  input logic         out_trap,
  input logic         flag_n,
  input logic         flag_z
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_link_we)
      && $stable(out_trap) && $stable(out_link_data));

  // R11
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R2
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_op == 4'd1) |=> $stable(flag_n) && $stable(flag_z));

  // R2
  cmp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd1 |=> flag_z == ($past(in_rega) == $past(in_regb))
      && flag_n == ($past(in_rega) < $past(in_regb)));

  // R8
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd8 |=> out_next_pc == $past(in_rega) && !out_link_we && !out_trap);

  // R9
  link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd9 |=> out_link_we && out_link_data == $past(in_pc) + 32'd4
      && out_next_pc == $past(in_rega));

  // R10
  trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd10 |=> out_trap && !out_link_we && out_next_pc == $past(in_pc) + 32'd4);

  // R12
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op != 4'd9 && in_op != 4'd10 |=> !out_link_we && !out_trap);
endmodule

bind cbu_branch_unit cbu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cbu_branch_unit.sv
`timescale 1ns/100ps
module sim_cbu_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_rega = '0, in_regb = '0, in_imm = '0, in_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_next_pc, out_link_data;
  logic        out_link_we, out_trap;
  logic [4:0]  out_link_reg;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_n = 0, m_z = 0;
  logic [65:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cbu_branch_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8: return "R8";
      4'd9: return "R9";
      4'd10: return "R10";
      default: return "R7";
    endcase
  endfunction

  // expected {next_pc, link_we, link_data, trap}; also updates the flag model
  function automatic logic [65:0] model(input logic [3:0] op, input logic [31:0] a, b, imm, pc);
    bit t = 0;
    logic [31:0] np = pc + 32'd4;
    bit lw = 0, tr = 0;
    case (op)
      4'd2: t = m_z;
      4'd3: t = !m_z;
      4'd4: t = m_n;
      4'd5: t = !m_n;
      4'd6: t = m_z || m_n;
      4'd7: t = !m_z && !m_n;
      4'd8: np = a;
      4'd9: begin np = a; lw = 1; end
      4'd10: tr = 1;
      default: ;
    endcase
    if (t) np = pc + imm * 32'd4; // R6
    if (op == 4'd1) begin
      m_z = (a == b);
      m_n = (a < b);
    end
    return {np, lw, pc + 32'd4, tr};
  endfunction

  task automatic check_outputs();
    logic [65:0] act = {out_next_pc, out_link_we, out_link_data, out_trap};
    logic [65:0] e;
    // R11: valid exactly while a result is owed
    chk(out_valid == (exp_q.size() > 0), "R11 out_valid", {65'd0, out_valid}, {65'd0, exp_q.size() > 0});
    if (exp_q.size() > 0 && out_valid) begin
      e = exp_q[0];
      if (!e[32]) begin
        act[31:1] = '0;
        e[31:1] = '0;
      end
      chk(act == e, tag_q[0], act, e);
      chk(out_link_reg == 5'd31, "R9 link reg", {61'd0, out_link_reg}, 66'd31);
    end
  endtask

  // called just after inputs change, before the next rising edge
  task automatic account(output bit accepted);
    bit exp_rdy = (exp_q.size() == 0) || out_ready;
    chk(in_ready == exp_rdy, "R11 in_ready", {65'd0, in_ready}, {65'd0, exp_rdy});
    if (out_valid && out_ready && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(model(in_op, in_rega, in_regb, in_imm, in_pc));
      tag_q.push_back(in_op inside {[4'd2:4'd7]} ? {tag_of(in_op), "/R6/R7"} : tag_of(in_op));
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, b, imm, pc, input bit stall);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      check_outputs();
      in_valid = 1; in_op = op; in_rega = a; in_regb = b; in_imm = imm; in_pc = pc;
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      #1;
      account(done);
    end
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      in_valid = 0;
      out_ready = 1;
      #1;
      account(acc);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", {65'd0, out_valid}, 66'd0);
    chk(in_ready == 1, "R1 in_ready", {65'd0, in_ready}, 66'd1);
    rst_n = 1;
    // R1: flags zero, so BNE and BGE are taken, BEQ/BLT not
    issue(4'd3, 0, 0, 32'd5, 32'h100, 0);
    issue(4'd5, 0, 0, 32'd2, 32'h200, 0);
    issue(4'd2, 0, 0, 32'd7, 32'h300, 0);
    issue(4'd4, 0, 0, 32'd7, 32'h400, 0);
    // R2..R5 under equal, unsigned-below and above
    issue(4'd1, 32'h1234, 32'h1234, 0, 32'h500, 0);
    for (int o = 2; o <= 7; o++) issue(o[3:0], 0, 0, 32'hFFFF_FFFE, 32'h1000, 0);
    issue(4'd1, 32'd1, 32'hFFFF_FFFF, 0, 32'h600, 0);
    for (int o = 2; o <= 7; o++) issue(o[3:0], 0, 0, 32'd3, 32'h2000, 0);
    issue(4'd1, 32'h8000_0000, 32'd5, 0, 32'h700, 0);
    for (int o = 2; o <= 7; o++) issue(o[3:0], 0, 0, 32'hFFFF_8000, 32'h3000, 0);
    // R8 R9 R10 R12 R7
    issue(4'd8, 32'hDEAD_BEE0, 0, 0, 32'h800, 0);
    issue(4'd9, 32'h0000_4000, 0, 0, 32'h900, 0);
    issue(4'd10, 32'h55, 0, 0, 32'hA00, 0);
    issue(4'd0, 32'h55, 0, 0, 32'hFFFF_FFFC, 0);
    issue(4'd12, 32'h55, 0, 0, 32'hB00, 0);
    idle(2);
    // R11 random traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op = $urandom % 16;
      logic [31:0] a = ($urandom % 4 == 0) ? 32'd9 : $urandom;
      logic [31:0] b = ($urandom % 4 == 0) ? 32'd9 : $urandom;
      logic [31:0] imm = {{16{1'b0}}, 16'($urandom)};
      if (imm[15]) imm[31:16] = 16'hFFFF;
      issue(op, a, b, imm, {$urandom} & 32'hFFFF_FFFC, 1);
      if ($urandom % 5 == 0) idle(1);
    end
    idle(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule